// File: doc/BRIEF.md
# DSP Core Control and Clear Sequencer

This block holds the 16-bit control word of a small audio processing core and turns it into the signals that make a program or coefficient reload safe. Two hold bits, one active low and one active high, force the core's accumulators and its serial input and output registers to zero. The active-low bit resets to 0, so the core comes up held. A self-clearing command bit starts a sequencer that walks every data-memory address and writes zero there, one word per clock. Core writes to the data memory are blocked while that bit reads 1.

A separate bit asks the slew engine to ramp the main volume down. Clearing it asks for a ramp back up. A read-only status bit reports that the requested ramp-down has finished. Software sets the hold bits, reloads memory, runs the clear and then releases the holds. When the volume is under slew control, it brackets the whole sequence with the ramp request and polls the status bit.

The clear sequencer has three named states. CLR_IDLE moves to CLR_RUN on a start command. CLR_RUN moves to CLR_DONE after it has written the last address. CLR_DONE always returns to CLR_IDLE, and in that cycle the command bit is cleared.

Top module: `core_ctl_seq`

## Requirements
- R1: After reset, `rd_data` reads 0, `core_hold` is 1, `ramp_req` is 0 and `dm_we` is 0.
- R2: `core_hold` is 0 only when bit 9 reads 1 and bit 6 reads 0. Bit 9 is the active-low hold and bit 6 is the active-high hold.
- R3: A write stores bits 6, 9 and 12 from `wr_data`, with the result visible in `rd_data` on the cycle after the write. All bits other than 6, 7, 9, 12 and 13 read 0, and writes to them have no effect. Bit 13 is never written by software.
- R4: A write with bit 7 set while bit 7 reads 0 starts a clear. In the `DM_DEPTH` cycles that follow the write edge, `dm_we` is 1 and `dm_addr` steps 0, 1, … `DM_DEPTH-1`, with `dm_wdata` equal to 0 throughout.
- R5: Bit 7 reads 1 for exactly `DM_DEPTH+1` cycles after the start write: the clear cycles plus one CLR_DONE cycle. It then returns to 0 with no write from software.
- R6: While bit 7 reads 1, a software write of either 0 or 1 to bit 7 neither stops nor restarts the clear.
- R7: While bit 7 reads 0, `dm_we`, `dm_addr` and `dm_wdata` follow `core_we`, `core_addr` and `core_wdata`. While bit 7 reads 1, core writes never reach the data memory.
- R8: A clear holds bit 7 high for at most `CLR_BUDGET` cycles.
- R9: `ramp_req` equals bit 12 of the register.
- R10: Bit 13 becomes 1 on the cycle after a `ramp_done` pulse that arrives while bit 12 reads 1. A `ramp_done` that arrives while bit 12 reads 0 leaves bit 13 at 0.
- R11: Bit 13 clears on a write that clears bit 12, and on a write that sets bit 12 while it reads 0. Such a write wins over a `ramp_done` pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 16 | Control register write value |
| rd_data | output | 16 | Control register and status readback |
| core_hold | output | 1 | Zero and hold accumulators and serial registers |
| ramp_req | output | 1 | Volume ramp-down request to the slew engine |
| ramp_done | input | 1 | One-cycle pulse from the slew engine: ramp-down finished |
| core_we | input | 1 | Data-memory write enable from the core |
| core_addr | input | AW | Data-memory address from the core |
| core_wdata | input | DATA_W | Data-memory write word from the core |
| dm_we | output | 1 | Data-memory write enable |
| dm_addr | output | AW | Data-memory address |
| dm_wdata | output | DATA_W | Data-memory write word |

## Verification
Directed sequences cover three cases:
- the power-up hold followed by the release of the holds;
- a clear that is attacked in flight by writes of 0 and of 1 to its command bit, which separates a correct self-clearing bit from one that can be cancelled or restarted;
- a ramp handshake in which a repeated set of bit 12 must keep the status flag, while a clear of bit 12, a fresh set and a stray `ramp_done` must each reset it or leave it at 0.

Random write values, random core memory traffic and random `ramp_done` pulses then vary the hold-bit combinations and the overlap of core writes with clears. This mix tells the pass-through path apart from the blocked path, and it tells a start write issued in the CLR_DONE cycle apart from one issued once the sequencer is idle.

// File: rtl/core_ctl_pkg.sv
package core_ctl_pkg;

    localparam int CTL_W    = 16;
    localparam int B_HOLD_H = 6;   // active-high hold
    localparam int B_CLR    = 7;   // self-clearing clear command
    localparam int B_HOLD_L = 9;   // active-low hold
    localparam int B_RAMP   = 12;  // ramp-down request
    localparam int B_RDONE  = 13;  // ramp-down complete (read only)

    typedef enum logic [1:0] {
        CLR_IDLE = 2'd0,
        CLR_RUN  = 2'd1,
        CLR_DONE = 2'd2
    } clr_state_t;

endpackage

// File: rtl/core_ctl_reg.sv
module core_ctl_reg
    import core_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             clr_done,
    input  logic             ramp_done,
    output logic             clr_start,
    output logic [CTL_W-1:0] ctl_q
);

    logic hold_h_q, clr_q, hold_l_q, ramp_q, rdone_q;
    logic new_ramp_wr;
    logic unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[CTL_W-1:B_RDONE], wr_data[11:10],
                              wr_data[8], wr_data[5:0]};

    // A start is only accepted while no clear is pending.
    assign clr_start   = wr_en & wr_data[B_CLR] & ~clr_q;
    // Either clearing the request or starting a fresh ramp-down resets status.
    assign new_ramp_wr = wr_en & (~wr_data[B_RAMP] | ~ramp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_h_q <= 1'b0;
            clr_q    <= 1'b0;
            hold_l_q <= 1'b0;
            ramp_q   <= 1'b0;
            rdone_q  <= 1'b0;
        end else begin
            if (wr_en) begin
                hold_h_q <= wr_data[B_HOLD_H];
                hold_l_q <= wr_data[B_HOLD_L];
                ramp_q   <= wr_data[B_RAMP];
            end
            if (clr_start) begin
                clr_q <= 1'b1;
            end else if (clr_done) begin
                clr_q <= 1'b0;
            end
            if (new_ramp_wr) begin
                rdone_q <= 1'b0;
            end else if (ramp_q && ramp_done) begin
                rdone_q <= 1'b1;
            end
        end
    end

    always_comb begin
        ctl_q           = '0;
        ctl_q[B_HOLD_H] = hold_h_q;
        ctl_q[B_CLR]    = clr_q;
        ctl_q[B_HOLD_L] = hold_l_q;
        ctl_q[B_RAMP]   = ramp_q;
        ctl_q[B_RDONE]  = rdone_q;
    end

endmodule

// File: rtl/core_clr_fsm.sv
module core_clr_fsm
    import core_ctl_pkg::*;
#(
    parameter int DM_DEPTH = 32,
    parameter int AW       = $clog2(DM_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_start,
    output logic          clr_we,
    output logic [AW-1:0] clr_addr,
    output logic          clr_done
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(DM_DEPTH - 1);

    clr_state_t    state_q, state_d;
    logic [AW-1:0] addr_q;

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CLR_IDLE: if (clr_start) state_d = CLR_RUN;
            CLR_RUN:  if (addr_q == LAST_ADDR) state_d = CLR_DONE;
            CLR_DONE: state_d = CLR_IDLE;
            default:  state_d = CLR_IDLE;
        endcase
    end

    // State register and address walker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CLR_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= (state_q == CLR_RUN) ? addr_q + 1'b1 : '0;
        end
    end

    // Outputs
    always_comb begin
        clr_we   = 1'b0;
        clr_done = 1'b0;
        unique case (state_q)
            CLR_IDLE: ;
            CLR_RUN:  clr_we   = 1'b1;
            CLR_DONE: clr_done = 1'b1;
            default:  ;
        endcase
        clr_addr = addr_q;
    end

endmodule

// File: rtl/core_dm_arb.sv
module core_dm_arb #(
    parameter int AW     = 5,
    parameter int DATA_W = 28
) (
    input  logic              busy,
    input  logic              clr_we,
    input  logic [AW-1:0]     clr_addr,
    input  logic              core_we,
    input  logic [AW-1:0]     core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic              dm_we,
    output logic [AW-1:0]     dm_addr,
    output logic [DATA_W-1:0] dm_wdata
);

    always_comb begin
        if (busy) begin
            dm_we    = clr_we;
            dm_addr  = clr_addr;
            dm_wdata = '0;
        end else begin
            dm_we    = core_we;
            dm_addr  = core_addr;
            dm_wdata = core_wdata;
        end
    end

endmodule

// File: rtl/core_ctl_seq.sv
module core_ctl_seq
    import core_ctl_pkg::*;
#(
    parameter int DM_DEPTH   = 32,
    parameter int DATA_W     = 28,
    parameter int CLR_BUDGET = 64,
    parameter int AW         = $clog2(DM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTL_W-1:0]  wr_data,
    output logic [CTL_W-1:0]  rd_data,
    output logic              core_hold,
    output logic              ramp_req,
    input  logic              ramp_done,
    input  logic              core_we,
    input  logic [AW-1:0]     core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic              dm_we,
    output logic [AW-1:0]     dm_addr,
    output logic [DATA_W-1:0] dm_wdata
);

    logic          clr_start, clr_done, clr_we;
    logic [AW-1:0] clr_addr;
    logic [CTL_W-1:0] ctl_q;

    core_ctl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .clr_done  (clr_done),
        .ramp_done (ramp_done),
        .clr_start (clr_start),
        .ctl_q     (ctl_q)
    );

    core_clr_fsm #(.DM_DEPTH(DM_DEPTH), .AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_start (clr_start),
        .clr_we    (clr_we),
        .clr_addr  (clr_addr),
        .clr_done  (clr_done)
    );

    core_dm_arb #(.AW(AW), .DATA_W(DATA_W)) u_arb (
        .busy       (ctl_q[B_CLR]),
        .clr_we     (clr_we),
        .clr_addr   (clr_addr),
        .core_we    (core_we),
        .core_addr  (core_addr),
        .core_wdata (core_wdata),
        .dm_we      (dm_we),
        .dm_addr    (dm_addr),
        .dm_wdata   (dm_wdata)
    );

    assign rd_data   = ctl_q;
    assign core_hold = ~ctl_q[B_HOLD_L] | ctl_q[B_HOLD_H];
    assign ramp_req  = ctl_q[B_RAMP];

endmodule

// File: rtl/core_ctl_seq_chk.sv
module core_ctl_seq_chk #(
    parameter int DM_DEPTH   = 32,
    parameter int DATA_W     = 28,
    parameter int CLR_BUDGET = 64,
    parameter int AW         = $clog2(DM_DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       rd_data,
    input logic              ramp_done,
    input logic              dm_we,
    input logic [AW-1:0]     dm_addr,
    input logic [DATA_W-1:0] dm_wdata
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(DM_DEPTH - 1);

    int unsigned busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          busy_cnt <= 0;
        else if (rd_data[7]) busy_cnt <= busy_cnt + 1;
        else                 busy_cnt <= 0;
    end

    assert_clear_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[7]) |-> dm_we && dm_addr == '0);

    assert_clear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] && dm_we && dm_addr != LAST_ADDR)
        |=> dm_we && dm_addr == $past(dm_addr) + 1'b1);

    assert_no_core_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] && dm_we) |-> dm_wdata == '0);

    assert_stays_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] && dm_we) |=> rd_data[7]);

    assert_budget_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= CLR_BUDGET);

    assert_done_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[13]) |-> $past(ramp_done) && $past(rd_data[12]));

    assert_done_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[12]) |-> !rd_data[13]);

endmodule

bind core_ctl_seq core_ctl_seq_chk #(
    .DM_DEPTH   (DM_DEPTH),
    .DATA_W     (DATA_W),
    .CLR_BUDGET (CLR_BUDGET),
    .AW         (AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_data   (rd_data),
    .ramp_done (ramp_done),
    .dm_we     (dm_we),
    .dm_addr   (dm_addr),
    .dm_wdata  (dm_wdata)
);

// File: tb/core_ctl_seq_tb.sv
`timescale 1ns/1ps
module core_ctl_seq_tb;

    localparam int DM_DEPTH   = 32;
    localparam int DATA_W     = 28;
    localparam int CLR_BUDGET = 64;
    localparam int AW         = $clog2(DM_DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [15:0]       wr_data = '0;
    logic [15:0]       rd_data;
    logic              core_hold, ramp_req;
    logic              ramp_done = 1'b0;
    logic              core_we = 1'b0;
    logic [AW-1:0]     core_addr = '0;
    logic [DATA_W-1:0] core_wdata = '0;
    logic              dm_we;
    logic [AW-1:0]     dm_addr;
    logic [DATA_W-1:0] dm_wdata;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    core_ctl_seq #(.DM_DEPTH(DM_DEPTH), .DATA_W(DATA_W), .CLR_BUDGET(CLR_BUDGET)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .core_hold(core_hold), .ramp_req(ramp_req), .ramp_done(ramp_done),
        .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
        .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata)
    );

    // Reference model built from the requirements
    logic m6, m9, m12, m13;
    int   m_left;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m6 <= 0; m9 <= 0; m12 <= 0; m13 <= 0; m_left <= 0;
        end else begin
            if (m_left > 0)                m_left <= m_left - 1;
            else if (wr_en && wr_data[7])  m_left <= DM_DEPTH + 1;
            if (wr_en) begin
                m6 <= wr_data[6]; m9 <= wr_data[9]; m12 <= wr_data[12];
            end
            if (wr_en && (!wr_data[12] || !m12)) m13 <= 0;
            else if (m12 && ramp_done)           m13 <= 1;
        end
    end

    function automatic logic [15:0] exp_rd();
        logic [15:0] v = '0;
        v[6] = m6; v[7] = (m_left > 0); v[9] = m9; v[12] = m12; v[13] = m13;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [15:0] e = exp_rd();
        chk("R3 stored bits", 32'(rd_data & 16'h1240), 32'(e & 16'h1240));
        chk("R3 undefined bits", 32'(rd_data & ~16'h32C0), 32'h0);
        chk("R5 clear bit", 32'(rd_data[7]), 32'(e[7]));
        chk("R10/R11 ramp status", 32'(rd_data[13]), 32'(e[13]));
        chk("R2 hold", 32'(core_hold), 32'(!m9 || m6));
        chk("R9 ramp request", 32'(ramp_req), 32'(m12));
        if (m_left > 0) begin
            chk("R4 clear we", 32'(dm_we), 32'(m_left > 1));
            if (m_left > 1) begin
                chk("R4 clear addr", 32'(dm_addr), 32'(DM_DEPTH + 1 - m_left));
                chk("R4 clear data", 32'(dm_wdata), 32'h0);
            end
        end else begin
            chk("R7 pass we", 32'(dm_we), 32'(core_we));
            if (core_we) begin
                chk("R7 pass addr", 32'(dm_addr), 32'(core_addr));
                chk("R7 pass data", 32'(dm_wdata), 32'(core_wdata));
            end
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        int busy_len;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rd_data", 32'(rd_data), 32'h0);
        chk("R1 hold", 32'(core_hold), 32'h1);
        chk("R1 ramp_req", 32'(ramp_req), 32'h0);
        chk("R1 dm_we", 32'(dm_we), 32'h0);
        rst_n = 1'b1;
        cyc();
        // R3: undefined bits ignored, then release holds (R2)
        wr(16'hFFFF & ~16'h1280);
        wr(16'h0200);
        cyc();
        // R4/R5/R6: clear with writes of 0 and 1 to bit 7 in flight
        core_we = 1'b1; core_addr = AW'(5); core_wdata = DATA_W'(28'h0ABCDEF);
        wr(16'h0280);
        busy_len = 1;
        wr(16'h0200);
        if (rd_data[7]) busy_len++;
        wr(16'h0280);
        if (rd_data[7]) busy_len++;
        while (rd_data[7] && busy_len < 200) begin
            cyc();
            if (rd_data[7]) busy_len++;
        end
        chk("R5/R6 clear length", 32'(busy_len), 32'(DM_DEPTH + 1));
        chk("R8 clear within budget", 32'(busy_len <= CLR_BUDGET), 32'h1);
        core_we = 1'b0;
        // R10/R11 ramp handshake
        wr(16'h1200);
        ramp_done = 1'b1; cyc(); ramp_done = 1'b0;
        chk("R10 status set", 32'(rd_data[13]), 32'h1);
        wr(16'h1200);
        chk("R11 repeat set keeps status", 32'(rd_data[13]), 32'h1);
        wr(16'h0200);
        chk("R11 clear drops status", 32'(rd_data[13]), 32'h0);
        ramp_done = 1'b1; cyc(); ramp_done = 1'b0;
        chk("R10 stray done ignored", 32'(rd_data[13]), 32'h0);
        ramp_done = 1'b1; wr(16'h1200); ramp_done = 1'b0;
        chk("R11 new start wins", 32'(rd_data[13]), 32'h0);
        // Random phase
        for (int i = 0; i < 5000; i++) begin
            wr_en      = ($urandom % 6) == 0;
            wr_data    = 16'($urandom);
            if ($urandom % 4 != 0) wr_data[9] = 1'b1;
            if ($urandom % 3 != 0) wr_data[7] = 1'b0;
            ramp_done  = ($urandom % 5) == 0;
            core_we    = $urandom % 2;
            core_addr  = AW'($urandom);
            core_wdata = DATA_W'($urandom);
            cyc();
        end
        wr_en = 1'b0; ramp_done = 1'b0; core_we = 1'b0;
        cyc();
        finish_run();
    end

endmodule